// File: doc/BRIEF.md
# Checked Configuration Image Loader

This block fills a local register file with a fixed-size configuration image held in a serial EEPROM. It starts on its own when reset is released. It fetches the image one byte at a time through a request/response port, and the bit-level serial engine behind that port is outside this block. Every request carries the device address and the memory address. The last byte of the image holds an 8-bit checksum. The block compares this byte with a CRC that it accumulates over all bytes before it.

When an attempt fails, the block starts the read again from the first address. An attempt fails on a checksum mismatch or on a response that is flagged as not acknowledged. After a fixed number of failed attempts the block gives up. It then raises a sticky error flag and a tristate request for the line drivers. A later load can be started from a shared error line. That line, already synchronized and compared against its threshold, must stay high for a minimum number of clocks and then fall.

The byte port uses a valid/ready handshake for back-pressure. `rd_valid` stays high, with `rd_dev` and `rd_addr` stable, until a clock edge at which `rd_ready` is also high. The responder presents `rd_data` and `rd_nack` in that same cycle. The responder may hold `rd_ready` low for as long as it needs.

Top module: `cfg_loader`

## Requirements
- R1: When reset is released, a load starts at once. `busy` and `rd_valid` are high, `rd_addr` is 0, `rd_dev` is 7'h50, and `done`, `err` and `tri_en` are low.
- R2: Within one attempt, the addresses run from 0 up to 47 in steps of one. A pending request keeps `rd_addr` stable and `rd_valid` high until it is accepted.
- R3: The CRC starts at 8'h01 and uses the polynomial x^8+x^4+x^3+x^2+1 (8'h1D). It processes each byte MSB first over addresses 0..46. When the CRC equals the byte at address 47, `done` rises and `cfg_regs[8*i+7:8*i]` holds the byte read from address i, for all 48 bytes.
- R4: A checksum mismatch, or a response with `rd_nack` high, ends the attempt. The next request is then made to address 0.
- R5: When the fourth consecutive attempt fails, `err` and `tri_en` go high, `done` stays low and no further requests are made.
- R6: If `err_lvl` is high for at least 4 clock edges and then low at an edge while the block is idle, a new load starts from address 0.
- R7: If `err_lvl` is high for fewer than 4 edges before it falls, no load is started.
- R8: A falling edge of `err_lvl` that occurs while a load is in progress starts no extra load.
- R9: A load that succeeds clears `err` and `tri_en`. Every load gets a fresh budget of 4 attempts.
- R10: `done` is low while a load is in progress and after a load that failed. It goes high only after a checksum match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| err_lvl | input | 1 | Synchronized error-line threshold level |
| rd_valid | output | 1 | Byte-read request pending |
| rd_ready | input | 1 | Request accepted; response valid this cycle |
| rd_dev | output | 7 | EEPROM device address |
| rd_addr | output | 8 | EEPROM memory address |
| rd_data | input | 8 | Returned byte |
| rd_nack | input | 1 | Response was not acknowledged |
| busy | output | 1 | Load in progress |
| done | output | 1 | Image loaded and checksum matched |
| err | output | 1 | Load gave up after the attempt limit |
| tri_en | output | 1 | Request to tristate the output drivers |
| cfg_regs | output | 384 | Loaded image, byte i at bits 8i+7:8i |

## Verification
The bench uses the default parameters: 48 image bytes, 4 attempts and a 4-clock hold on the error line. With these values, exhausting the retries costs fewer than 200 accepted reads, so each run reaches the give-up path several times. The bench's EEPROM model can corrupt the checksum byte for a chosen number of attempts, or refuse one byte. Each success-after-N-failures count from 0 to 3 can therefore be set up, as well as the give-up case. A hold of exactly 4 edges versus 3 edges puts the boundary of the error-line qualifier under test.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_READ = 1'b1
  } ld_state_t;

  // One byte of MSB-first CRC update with an 8-bit truncated polynomial.
  function automatic logic [7:0] crc8_byte(input logic [7:0] crc_in,
                                            input logic [7:0] din,
                                            input logic [7:0] poly);
    logic [7:0] c;
    c = crc_in;
    for (int b = 7; b >= 0; b--) begin
      if (c[7] != din[b]) c = {c[6:0], 1'b0} ^ poly;
      else                c = {c[6:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/cfg_reload_qual.sv
module cfg_reload_qual #(
  parameter int HOLD_MIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic fire
);
  localparam int CW = $clog2(HOLD_MIN + 1);

  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= '0;
    else if (lvl) hi_cnt <= (hi_cnt == CW'(HOLD_MIN)) ? hi_cnt : hi_cnt + 1'b1;
    else hi_cnt <= '0;
  end

  // Low now, after a saturated run of high samples: a qualified falling edge.
  assign fire = !lvl && (hi_cnt == CW'(HOLD_MIN));
endmodule

// File: rtl/cfg_crc8.sv
module cfg_crc8 #(
  parameter logic [7:0] POLY = 8'h1D,
  parameter logic [7:0] INIT = 8'h01
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  import cfg_loader_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= INIT;
    else if (en)    crc <= crc8_byte(crc, din, POLY);
  end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter int NBYTES = 48,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [7:0]        wdata,
  output logic [NBYTES*8-1:0] q
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) q[8*i +: 8] <= '0;
      else if (we && waddr == AW'(i)) q[8*i +: 8] <= wdata;
    end
  end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int          IMG_BYTES = 48,
  parameter int          MAX_TRIES = 4,
  parameter int          HOLD_MIN  = 4,
  parameter int          ADDR_W    = 8,
  parameter logic [6:0]  DEV_ID    = 7'h50,
  parameter logic [7:0]  CRC_POLY  = 8'h1D,
  parameter logic [7:0]  CRC_INIT  = 8'h01
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   err_lvl,
  output logic                   rd_valid,
  input  logic                   rd_ready,
  output logic [6:0]             rd_dev,
  output logic [ADDR_W-1:0]      rd_addr,
  input  logic [7:0]             rd_data,
  input  logic                   rd_nack,
  output logic                   busy,
  output logic                   done,
  output logic                   err,
  output logic                   tri_en,
  output logic [IMG_BYTES*8-1:0] cfg_regs
);
  import cfg_loader_pkg::*;

  localparam int AW   = $clog2(IMG_BYTES);
  localparam int TW   = $clog2(MAX_TRIES + 1);
  localparam logic [AW-1:0] LAST = AW'(IMG_BYTES - 1);

  ld_state_t     state;
  logic [AW-1:0] addr;
  logic [TW-1:0] fails;
  logic [7:0]    crc;
  logic          fire, hs, last, good, bad, start;

  cfg_reload_qual #(.HOLD_MIN(HOLD_MIN)) u_qual (
    .clk(clk), .rst(rst), .lvl(err_lvl), .fire(fire)
  );

  assign hs    = rd_valid && rd_ready;
  assign last  = (addr == LAST);
  assign good  = hs && !rd_nack && last && (crc == rd_data);
  assign bad   = hs && (rd_nack || (last && crc != rd_data));
  assign start = (state == ST_IDLE) && fire;

  cfg_crc8 #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk(clk), .rst(rst), .clr(start || bad),
    .en(hs && !rd_nack && !last), .din(rd_data), .crc(crc)
  );

  cfg_regfile #(.NBYTES(IMG_BYTES), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .we(hs && !rd_nack),
    .waddr(addr), .wdata(rd_data), .q(cfg_regs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_READ;
      addr   <= '0;
      fails  <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
      tri_en <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (fire) begin
          state <= ST_READ;
          addr  <= '0;
          fails <= '0;
          done  <= 1'b0;
        end
        ST_READ: begin
          if (good) begin
            state  <= ST_IDLE;
            done   <= 1'b1;
            err    <= 1'b0;
            tri_en <= 1'b0;
            fails  <= '0;
          end else if (bad) begin
            addr <= '0;
            if (fails == TW'(MAX_TRIES - 1)) begin
              state  <= ST_IDLE;
              err    <= 1'b1;
              tri_en <= 1'b1;
            end else begin
              fails <= fails + 1'b1;
            end
          end else if (hs) begin
            addr <= addr + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rd_valid = (state == ST_READ);
  assign busy     = (state == ST_READ);
  assign rd_dev   = DEV_ID;
  assign rd_addr  = ADDR_W'(addr);
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int IMG_BYTES = 48,
  parameter int ADDR_W    = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_nack,
  input logic              done,
  input logic              err,
  input logic              tri_en
);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(IMG_BYTES - 1);

  assert_addr_range_R2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_addr <= LAST_A);

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  assert_done_after_check_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(rd_valid && rd_ready && !rd_nack && rd_addr == LAST_A));

  assert_nack_restart_R4: assert property (@(posedge clk) disable iff (rst)
    rd_valid && rd_ready && rd_nack |=> !rd_valid || rd_addr == '0);

  assert_give_up_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(tri_en) |-> !rd_valid && err && !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !rd_valid);
endmodule

bind cfg_loader cfg_loader_chk #(.IMG_BYTES(IMG_BYTES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_addr(rd_addr), .rd_nack(rd_nack), .done(done), .err(err), .tri_en(tri_en)
);

// File: tb/test_cfg_loader.sv
module test_cfg_loader;
  localparam int N = 48;

  logic clk = 1'b0, rst = 1'b1, err_lvl = 1'b0;
  logic rd_valid, rd_ready = 1'b0, rd_nack = 1'b0;
  logic [6:0] rd_dev;
  logic [7:0] rd_addr, rd_data = 8'h00;
  logic busy, done, err, tri_en;
  logic [N*8-1:0] cfg_regs;

  int checks = 0, errors = 0, cycles = 0;
  int attempts = 0, bad_n = 0, nack_at = 0, proto_err = 0, prev_addr = 0;
  logic [7:0] img [N];

  always #4 clk = ~clk;

  cfg_loader i_cfg_loader (
    .clk(clk), .rst(rst), .err_lvl(err_lvl), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_dev(rd_dev), .rd_addr(rd_addr), .rd_data(rd_data), .rd_nack(rd_nack),
    .busy(busy), .done(done), .err(err), .tri_en(tri_en), .cfg_regs(cfg_regs)
  );

  function automatic logic [7:0] ref_crc();
    logic [7:0] c = 8'h01;
    for (int r = 0; r < N - 1; r++)
      for (int b = 7; b >= 0; b--)
        c = (c[7] != img[r][b]) ? ({c[6:0], 1'b0} ^ 8'h1D) : {c[6:0], 1'b0};
    return c;
  endfunction

  function automatic logic [N*8-1:0] packed_img();
    logic [N*8-1:0] v;
    for (int i = 0; i < N; i++) v[8*i +: 8] = img[i];
    return v;
  endfunction

  task automatic new_image();
    for (int i = 0; i < N - 1; i++) img[i] = 8'($urandom);
    img[N-1] = ref_crc();
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic arm(input int bad, input int nk);
    attempts = 0; bad_n = bad; nack_at = nk; proto_err = 0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
  endtask

  task automatic pulse(input int hold);
    @(negedge clk) err_lvl = 1'b1;
    repeat (hold) @(negedge clk);
    err_lvl = 1'b0;
  endtask

  // EEPROM responder model: random back-pressure, optional corruption or nack.
  initial begin
    forever begin
      @(negedge clk);
      rd_ready = 1'b0; rd_nack = 1'b0; rd_data = 8'h00;
      if (!rst && rd_valid && ($urandom % 4 != 0)) begin
        if (rd_addr == 8'd0) attempts++;
        else if (int'(rd_addr) != prev_addr + 1) proto_err++;
        if (rd_dev != 7'h50 || rd_addr >= 8'(N)) proto_err++;
        prev_addr = int'(rd_addr);
        rd_ready = 1'b1;
        rd_data  = img[rd_addr[5:0]];
        if (rd_addr == 8'(N - 1) && attempts <= bad_n) rd_data = rd_data ^ 8'h01;
        if (rd_addr == 8'd10 && attempts == nack_at) rd_nack = 1'b1;
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected below 150000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    new_image();
    arm(0, 0);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(busy && rd_valid && rd_addr == 0, "R1 start", {busy, rd_valid, rd_addr}, 10'h300);
    chk(rd_dev == 7'h50, "R1 dev", rd_dev, 7'h50);
    chk({done, err, tri_en} == 3'b000, "R1 flags", {done, err, tri_en}, 0);
    @(negedge clk);
    chk(!done, "R10 done low while busy", done, 0);
    wait_idle();
    chk(done && !err && !tri_en, "R3 done", {done, err, tri_en}, 3'b100);
    chk(cfg_regs == packed_img(), "R3 regs", cfg_regs[63:0], packed_img() >> 0);
    chk(attempts == 1 && proto_err == 0, "R2 order", proto_err, 0);

    // R7 short hold ignored
    arm(0, 0);
    pulse(3);
    repeat (10) @(negedge clk);
    chk(!busy && attempts == 0, "R7 short hold", attempts, 0);

    // R4 one checksum mismatch, then success
    new_image(); arm(1, 0);
    pulse(4);
    wait_idle();
    chk(done && attempts == 2, "R4 crc retry", attempts, 2);
    chk(cfg_regs == packed_img() && proto_err == 0, "R4 regs", proto_err, 0);

    // R4 nack counts as failure
    arm(0, 1);
    pulse(5);
    wait_idle();
    chk(done && attempts == 2, "R4 nack retry", attempts, 2);

    // R5 four failures
    arm(9, 0);
    pulse(4);
    wait_idle();
    chk(err && tri_en && !done, "R5 give up", {err, tri_en, done}, 3'b110);
    chk(attempts == 4, "R5 attempts", attempts, 4);
    repeat (20) @(negedge clk);
    chk(attempts == 4 && !rd_valid, "R5 no more requests", attempts, 4);

    // R6/R9 reload after error clears flags
    new_image(); arm(0, 0);
    pulse(6);
    repeat (3) @(negedge clk);
    chk(busy && !done, "R10 done low during reload", {busy, done}, 2'b10);
    wait_idle();
    chk(done && !err && !tri_en && attempts == 1, "R9 clear", {done, err, tri_en}, 3'b100);
    chk(cfg_regs == packed_img(), "R6 regs", cfg_regs[63:0], packed_img() >> 0);

    // R8 qualified fall during load ignored
    arm(0, 0);
    pulse(4);
    pulse(5);
    chk(busy, "R8 still busy at second fall", busy, 1);
    wait_idle();
    repeat (20) @(negedge clk);
    chk(attempts == 1 && !busy && done, "R8 no extra load", attempts, 1);

    // Random loads with mixed failure counts
    for (int k = 0; k < 8; k++) begin
      int r;
      r = int'($urandom % 5);
      new_image(); arm(r, 0);
      pulse(4 + int'($urandom % 5));
      wait_idle();
      chk(attempts == ((r < 4) ? r + 1 : 4), "R4 random attempts", attempts, (r < 4) ? r + 1 : 4);
      chk(done == (r < 4) && err == (r >= 4) && tri_en == (r >= 4), "R9 random flags",
          {done, err, tri_en}, (r < 4) ? 3'b100 : 3'b011);
      if (r < 4) chk(cfg_regs == packed_img(), "R3 random regs", cfg_regs[63:0], packed_img() >> 0);
      chk(proto_err == 0, "R2 random order", proto_err, 0);
    end

    finish_run();
  end
endmodule